// File: doc/BRIEF.md
# Six-Byte Framed SPI Parameter Transmitter

This block is an SPI master that sends one waveform parameter set to a remote slave. The set has six bytes: amplitude, waveform select, three two-digit decimal groups of the frequency and the millions digit. A single start pulse loads all six fields. The block then sends them as six separate one-byte transactions in a fixed order. Each transaction has its own active-low chip-select pulse. Between transactions chip select is held high long enough for an oversampling slave to see a clean end of message.

The slave rebuilds the frequency from the digit groups, so the order of the bytes is part of the interface. SCK idles low. Data leaves most significant bit first, changes on the falling edge and is sampled by the slave on the rising edge. The bit rate is set by a divider of the system clock, which the caller programs so that SCK runs near 1 Mbit/s. The block reports `busy` for the whole frame and pulses `done` once when the last byte's chip select is released.

Top module: `param_frame_spi_tx`

## Requirements
- R1: Bytes leave in the order amp, wave, freqPairLo, freqPairMid, freqPairHi, freqMillions. With those values the slave's frequency freqPairLo + 100*freqPairMid + 10000*freqPairHi + 1000000*freqMillions equals the value the caller encoded.
- R2: Each byte is framed by its own low pulse on `spiCsN`, so one frame has exactly six pulses. Between two pulses `spiCsN` stays high for 4 half-periods (two SCK periods). The same high time follows the sixth byte before `busy` falls.
- R3: Every chip-select pulse holds exactly eight rising edges of `spiSck`.
- R4: Bits go most significant first. `spiMosi` takes a new bit only when chip select falls or when SCK falls, so it is stable across every rising edge. `spiMosi` is 0 while `spiCsN` is high.
- R5: `spiSck` is low whenever `spiCsN` is high. Every SCK half-period, and the setup and gap half-periods, lasts `clkDiv`+1 system clocks. `clkDiv` is sampled at the accepting clock edge.
- R6: All six fields are captured at the accepting edge. Input changes during a frame have no effect on the bytes sent.
- R7: A start is accepted on a clock edge where `startReq`=1 and `busy`=0. At that edge `busy` rises, `spiCsN` goes low and `spiMosi` shows amp bit 7. `busy` stays high for 126*(`clkDiv`+1) clocks. A start while busy is ignored.
- R8: `done` is high for exactly one clock: the first clock in which `spiCsN` is high after the sixth byte.
- R9: While reset is asserted, `spiCsN`=1, `spiSck`=0, `spiMosi`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to send one parameter set |
| ampByte | input | 8 | Amplitude byte, sent first |
| waveByte | input | 8 | Waveform select byte, sent second |
| freqPairLo | input | 8 | Frequency tens and units (0..99) |
| freqPairMid | input | 8 | Frequency thousands and hundreds (0..99) |
| freqPairHi | input | 8 | Frequency hundred-thousands and ten-thousands (0..99) |
| freqMillions | input | 8 | Frequency millions digit |
| clkDiv | input | DIV_W | Half-period length minus one, in system clocks |
| spiSck | output | 1 | Serial clock, idles low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at the last byte's chip-select release |

## Verification
If the half-period timer or the position counter is wrong, SCK or chip select is off within `clkDiv`+1 clocks of the error. A per-clock comparison catches this in the same cycle. If the field index is wrong, SCK timing stays correct, but a wrong `spiMosi` value shows at the next setup half-period and the decoded byte order breaks R1 at the end of that transaction. A shift register that moves on the wrong edge shows up as a changed `spiMosi` while SCK is high, within one bit time. A faulty busy guard shows as an early restart of chip select or a changed byte stream after a start request in mid-frame.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int FIELD_COUNT = 6;
  localparam int BYTE_BITS   = 8;
  localparam int GAP_HALVES  = 4;
  localparam int DATA_HALVES = 2 * BYTE_BITS;
  localparam int LAST_POS_I  = DATA_HALVES + GAP_HALVES;
  localparam int POS_W       = $clog2(LAST_POS_I + 1);
  localparam int IDX_W       = $clog2(FIELD_COUNT);

  localparam logic [POS_W-1:0] POS_LAST_DATA = POS_W'(DATA_HALVES);
  localparam logic [POS_W-1:0] POS_CS_OFF    = POS_W'(DATA_HALVES + 1);
  localparam logic [POS_W-1:0] POS_LAST      = POS_W'(LAST_POS_I);
  localparam logic [IDX_W-1:0] IDX_LAST      = IDX_W'(FIELD_COUNT - 1);

  typedef struct packed {
    logic loadFrame;
    logic loadByte;
    logic shiftBit;
    logic sckHigh;
    logic sckLow;
    logic csRelease;
  } dpCtrl_t;
endpackage

// File: rtl/sbf_halftimer.sv
module sbf_halftimer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divIn,
  output logic             tick
);
  logic [DIV_W-1:0] divLatch;
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == divLatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLatch <= '0;
      cnt      <= '0;
    end else if (restart) begin
      divLatch <= divIn;
      cnt      <= '0;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= divLatch);
endmodule

// File: rtl/sbf_ctrl.sv
module sbf_ctrl
  import sbf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] nextField,
  output dpCtrl_t          ctl
);
  logic [POS_W-1:0] pos, posN;
  logic [IDX_W-1:0] fieldIdx, fieldIdxN;
  logic             busyN, doneN;
  logic             accept;

  assign accept = startReq && !busy;

  always_comb begin
    ctl       = '0;
    posN      = pos;
    fieldIdxN = fieldIdx;
    busyN     = busy;
    doneN     = 1'b0;
    nextField = fieldIdx + 1'b1;
    if (accept) begin
      ctl.loadFrame = 1'b1;
      ctl.loadByte  = 1'b1;
      nextField     = '0;
      posN          = '0;
      fieldIdxN     = '0;
      busyN         = 1'b1;
    end else if (busy && tick) begin
      if (pos == POS_LAST) begin
        posN = '0;
        if (fieldIdx == IDX_LAST) begin
          busyN = 1'b0;
        end else begin
          fieldIdxN    = fieldIdx + 1'b1;
          ctl.loadByte = 1'b1;
        end
      end else begin
        posN = pos + 1'b1;
        if (posN <= POS_LAST_DATA) begin
          if (posN[0]) begin
            ctl.sckHigh = 1'b1;
          end else begin
            ctl.sckLow   = 1'b1;
            ctl.shiftBit = 1'b1;
          end
        end
        if (posN == POS_CS_OFF) begin
          ctl.csRelease = 1'b1;
          doneN         = (fieldIdx == IDX_LAST);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos      <= '0;
      fieldIdx <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      pos      <= posN;
      fieldIdx <= fieldIdxN;
      busy     <= busyN;
      done     <= doneN;
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_last_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busy && fieldIdx == IDX_LAST));
endmodule

// File: rtl/sbf_dp.sv
module sbf_dp
  import sbf_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  dpCtrl_t                               ctl,
  input  logic [IDX_W-1:0]                      nextField,
  input  logic [FIELD_COUNT-1:0][BYTE_BITS-1:0] fieldIn,
  output logic                                  sck,
  output logic                                  csN,
  output logic                                  mosi
);
  logic [FIELD_COUNT-1:0][BYTE_BITS-1:0] fieldStore;
  logic [BYTE_BITS-1:0]                  shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldStore <= '0;
    end else if (ctl.loadFrame) begin
      for (int f = 0; f < FIELD_COUNT; f++) begin
        fieldStore[f] <= fieldIn[f];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadFrame) begin
      shiftReg <= fieldIn[0];
    end else if (ctl.loadByte) begin
      shiftReg <= fieldStore[nextField];
    end else if (ctl.shiftBit) begin
      shiftReg <= {shiftReg[BYTE_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN <= 1'b1;
      sck <= 1'b0;
    end else begin
      if (ctl.loadByte) csN <= 1'b0;
      else if (ctl.csRelease) csN <= 1'b1;
      if (ctl.sckHigh) sck <= 1'b1;
      else if (ctl.sckLow) sck <= 1'b0;
    end
  end

  assign mosi = csN ? 1'b0 : shiftReg[BYTE_BITS-1];

  // R5
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R4
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));
endmodule

// File: rtl/param_frame_spi_tx.sv
module param_frame_spi_tx
  import sbf_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [7:0]       ampByte,
  input  logic [7:0]       waveByte,
  input  logic [7:0]       freqPairLo,
  input  logic [7:0]       freqPairMid,
  input  logic [7:0]       freqPairHi,
  input  logic [7:0]       freqMillions,
  input  logic [DIV_W-1:0] clkDiv,
  output logic             spiSck,
  output logic             spiCsN,
  output logic             spiMosi,
  output logic             busy,
  output logic             done
);
  dpCtrl_t                               ctl;
  logic [IDX_W-1:0]                      nextField;
  logic                                  tick;
  logic [FIELD_COUNT-1:0][BYTE_BITS-1:0] fieldIn;

  assign fieldIn = {freqMillions, freqPairHi, freqPairMid, freqPairLo, waveByte, ampByte};

  sbf_halftimer #(.DIV_W(DIV_W)) i_timer (
    .clk    (clk),
    .rstN   (rstN),
    .restart(ctl.loadFrame),
    .run    (busy),
    .divIn  (clkDiv),
    .tick   (tick)
  );

  sbf_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .tick     (tick),
    .busy     (busy),
    .done     (done),
    .nextField(nextField),
    .ctl      (ctl)
  );

  sbf_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .nextField(nextField),
    .fieldIn  (fieldIn),
    .sck      (spiSck),
    .csN      (spiCsN),
    .mosi     (spiMosi)
  );

  // R8
  done_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $rose(spiCsN));
endmodule

// File: tb/test_param_frame_spi_tx.sv
module test_param_frame_spi_tx;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic [7:0] ampByte = '0, waveByte = '0, freqPairLo = '0;
  logic [7:0] freqPairMid = '0, freqPairHi = '0, freqMillions = '0;
  logic [7:0] clkDiv = '0;
  logic       spiSck, spiCsN, spiMosi, busy, done;

  int checks = 0;
  int errors = 0;
  int cycleNo = 0;

  // reference model state
  int   mN = -1;
  int   mH = 1;
  logic [7:0] mF [6];

  // byte decoder state
  logic prevSck = 1'b0, prevCs = 1'b1;
  logic [7:0] rxByte = '0;
  int   rxBits = 0;
  logic [7:0] rxQ [$];

  always #4 clk = ~clk;

  param_frame_spi_tx i_param_frame_spi_tx (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .ampByte(ampByte), .waveByte(waveByte), .freqPairLo(freqPairLo),
    .freqPairMid(freqPairMid), .freqPairHi(freqPairHi), .freqMillions(freqMillions),
    .clkDiv(clkDiv), .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d at cycle %0d", req, what, got, exp, cycleNo);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic compareOutputs();
    logic eCs, eSck, eMosi, eBusy, eDone;
    eCs = 1; eSck = 0; eMosi = 0; eBusy = 0; eDone = 0;
    if (mN >= 0) begin
      int half, bi, p, idx;
      half = mN / mH; bi = half / 21; p = half % 21;
      eBusy = 1;
      if (p <= 16) begin
        eCs  = 0;
        eSck = (p % 2) == 1;
        idx  = 7 - p / 2;
        eMosi = (idx >= 0) ? mF[bi][idx] : 1'b0;
      end
      eDone = (bi == 5) && (p == 17) && (mN % mH == 0);
    end
    chk("R2", "spiCsN", int'(spiCsN), int'(eCs));
    chk("R5", "spiSck", int'(spiSck), int'(eSck));
    chk("R4", "spiMosi", int'(spiMosi), int'(eMosi));
    chk("R7", "busy", int'(busy), int'(eBusy));
    chk("R8", "done", int'(done), int'(eDone));
    // slave-side byte decode: sample on SCK rise while selected
    if (!spiCsN && prevCs) rxBits = 0;
    if (!spiCsN && spiSck && !prevSck) begin
      rxByte = {rxByte[6:0], spiMosi};
      rxBits++;
    end
    if (spiCsN && !prevCs) begin
      chk("R3", "rising edges per select pulse", rxBits, 8);
      rxQ.push_back(rxByte);
    end
    prevSck = spiSck;
    prevCs  = spiCsN;
  endtask

  // called at a negedge; drives start, advances model over the posedge, compares at next negedge
  task automatic step(input logic st);
    bit wasIdle;
    startReq = st;
    @(posedge clk);
    cycleNo++;
    wasIdle = (mN < 0);
    if (mN >= 0) begin
      mN++;
      if (mN / mH >= 126) mN = -1;
    end
    if (wasIdle && st) begin
      mN = 0;
      mH = int'(clkDiv) + 1;
      mF[0] = ampByte; mF[1] = waveByte; mF[2] = freqPairLo;
      mF[3] = freqPairMid; mF[4] = freqPairHi; mF[5] = freqMillions;
    end
    @(negedge clk);
    compareOutputs();
  endtask

  task automatic setFields(input logic [7:0] a, w, lo, mid, hi, mil);
    ampByte = a; waveByte = w; freqPairLo = lo;
    freqPairMid = mid; freqPairHi = hi; freqMillions = mil;
  endtask

  task automatic drain();
    while (mN >= 0) step(1'b0);
    repeat (3) step(1'b0);
  endtask

  task automatic checkFrame(input string req, input logic [7:0] e0, e1, e2, e3, e4, e5);
    logic [7:0] exp [6];
    exp[0] = e0; exp[1] = e1; exp[2] = e2; exp[3] = e3; exp[4] = e4; exp[5] = e5;
    chk(req, "bytes available", (rxQ.size() >= 6) ? 6 : rxQ.size(), 6);
    if (rxQ.size() >= 6) begin
      for (int k = 0; k < 6; k++) begin
        logic [7:0] got;
        got = rxQ.pop_front();
        chk(req, $sformatf("byte %0d", k), int'(got), int'(exp[k]));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired busy got %0b exp 0", busy);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "spiCsN in reset", int'(spiCsN), 1);
    chk("R9", "spiSck in reset", int'(spiSck), 0);
    chk("R9", "spiMosi in reset", int'(spiMosi), 0);
    chk("R9", "busy in reset", int'(busy), 0);
    chk("R9", "done in reset", int'(done), 0);
    rstN = 1'b1;
    repeat (2) step(1'b0);

    // R1: fastest divider, frequency 2,345,678 as pairs 78/56/34 and digit 2
    clkDiv = 8'd0;
    setFields(8'd7, 8'd3, 8'd78, 8'd56, 8'd34, 8'd2);
    step(1'b1);
    drain();
    begin
      int f;
      f = 0;
      if (rxQ.size() >= 6) f = int'(rxQ[2]) + 100 * int'(rxQ[3]) + 10000 * int'(rxQ[4]) + 1000000 * int'(rxQ[5]);
      chk("R1", "rebuilt frequency", f, 2345678);
    end
    checkFrame("R1", 8'd7, 8'd3, 8'd78, 8'd56, 8'd34, 8'd2);

    // R6/R7: changes and a start request in mid-frame must not disturb the frame
    clkDiv = 8'd3;
    setFields(8'hA5, 8'h5A, 8'h01, 8'h80, 8'hC3, 8'h3C);
    step(1'b1);
    repeat (60) step(1'b0);
    setFields(8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00);
    clkDiv = 8'd1;          // R5: divider sampled only at start
    step(1'b1);             // R7: ignored while busy
    repeat (200) step(1'b0);
    step(1'b1);
    drain();
    checkFrame("R6", 8'hA5, 8'h5A, 8'h01, 8'h80, 8'hC3, 8'h3C);
    chk("R7", "no extra bytes after mid-frame start", rxQ.size(), 0);

    // R2/R7: start held high gives back-to-back frames after the closing gap
    clkDiv = 8'd1;
    setFields(8'hFF, 8'h00, 8'hFF, 8'h00, 8'h81, 8'h7E);
    repeat (2 * 126 * 2 + 5) step(1'b1);
    step(1'b0);
    drain();
    chk("R2", "whole frames from held start", (rxQ.size() % 6 == 0 && rxQ.size() >= 12) ? 1 : 0, 1);
    while (rxQ.size() >= 6)
      checkFrame("R2", 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h81, 8'h7E);

    // R5: longer half-period, alternating bit patterns
    clkDiv = 8'd6;
    setFields(8'h55, 8'hAA, 8'd99, 8'd0, 8'd50, 8'd5);
    step(1'b1);
    drain();
    checkFrame("R5", 8'h55, 8'hAA, 8'd99, 8'd0, 8'd50, 8'd5);

    summary();
    $finish;
  end
endmodule